// File: doc/BRIEF.md
# External and Timer Interrupt Request Flag Register

This block holds the interrupt control byte of a small microcontroller. The byte covers two external request pins and two timer overflow sources. Each external pin has its own mode bit. In level mode the pin drives its request directly: a low pin means a request. In edge mode a detected transition latches a sticky flag. A separate 4-bit edge-select register picks which transitions count in edge mode: rising, falling, both or none. Timer overflow pulses latch sticky timer flags. The two timer run bits in the same byte are plain storage, passed out to the timers.

The priority and vectoring logic downstream acknowledges a source with a one-clock pulse. That pulse clears an edge-mode external flag or a timer flag. It has no effect on a level-mode request. Software can rewrite the byte as a whole or one bit at a time, which lets it force or cancel a latched request. The pins are asynchronous, so each one passes through a two-flop synchronizer before any decision is made.

Top module: `extIrqFlagUnit`

## Requirements
- R1: After reset, the control byte reads 0x00, the edge-select register reads 4'b0101 (falling edges selected), and all four request outputs are 0.
- R2: Control byte bit positions are: 7 timer-1 flag, 6 timer-1 run, 5 timer-0 flag, 4 timer-0 run, 3 ext-1 flag, 2 ext-1 mode, 1 ext-0 flag, 0 ext-0 mode. A byte write loads the mode and run bits, and they hold until the next write. `runTmr` = {bit 6, bit 4}.
- R3: A single-bit write changes only the bit at `bitSel` to `bitVal`, in the cycle after the write. If it coincides with a byte write, the single-bit value wins for that bit.
- R4: With mode bit 0, the ext flag bit and `irqExt[x]` equal the inverse of the pin as it stood two clocks earlier. Acknowledge pulses and software writes to that flag do not change it.
- R5: With mode bit 1, a selected transition on pin x sets the flag. The flag is visible three clocks after the pin changes. Edge-select layout: bit 2x = falling enable and bit 2x+1 = rising enable for pin x.
- R6: When both enables of a pin are set, either transition sets its flag. When neither is set, no transition sets it.
- R7: An acknowledge pulse on an edge-mode ext flag clears it in the next cycle.
- R8: An overflow pulse sets the timer flag in the next cycle. An acknowledge pulse clears it in the next cycle.
- R9: A set event in the same cycle as an acknowledge or a software write to that flag leaves the flag set.
- R10: A software write to an edge-mode ext flag or to a timer flag forces the written value, provided no set event or acknowledge coincides with it.
- R11: `irqExt` and `irqTmr` equal the corresponding flag bits of the control byte as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 2 | External request pins, asynchronous |
| ovf | input | 2 | Timer overflow pulses |
| ackExt | input | 2 | Acknowledge pulses for the external requests |
| ackTmr | input | 2 | Acknowledge pulses for the timer requests |
| regWrEn | input | 1 | Control byte write strobe |
| regWrData | input | 8 | Control byte write data |
| bitWrEn | input | 1 | Single-bit write strobe |
| bitSel | input | 3 | Bit position for the single-bit write |
| bitVal | input | 1 | Value for the single-bit write |
| cfgWrEn | input | 1 | Edge-select register write strobe |
| cfgWrData | input | 4 | Edge-select register write data |
| regRdData | output | 8 | Control byte as read |
| cfgRdData | output | 4 | Edge-select register as read |
| irqExt | output | 2 | External request lines |
| irqTmr | output | 2 | Timer request lines |
| runTmr | output | 2 | Timer run bits |

## Verification
A corrupted flag register shows up on the request outputs and in the byte read in the next cycle. A faulty synchronizer or edge history shows up three clocks after a pin change, as a missed flag or an extra flag. A lost acknowledge or a wrong set-versus-clear priority leaves a request line in the wrong state one cycle after the coincident pulses. The bench compares every output against its model on every cycle, so any such error is reported within one to three clocks of the stimulus that exposes it.

// File: rtl/extIrqPkg.sv
package extIrqPkg;
  localparam int REG_W = 8;
  localparam int NUM_EXT = 2;
  localparam int NUM_TMR = 2;
  localparam int CFG_W = 2 * NUM_EXT;

  // bit positions in the control byte; decoded by software, so fixed
  localparam int BIT_EXT_MODE0 = 0;
  localparam int BIT_EXT_FLAG0 = 1;
  localparam int BIT_TMR_RUN0  = 4;
  localparam int BIT_TMR_FLAG0 = 5;
  localparam int EXT_STRIDE    = 2;
  localparam int TMR_STRIDE    = 2;

  typedef struct packed {
    logic [NUM_EXT-1:0] extSet;
    logic [NUM_EXT-1:0] extAck;
    logic [NUM_TMR-1:0] tmrSet;
    logic [NUM_TMR-1:0] tmrAck;
    logic [REG_W-1:0]   wrMask;
    logic [REG_W-1:0]   wrVal;
    logic               cfgWr;
    logic [CFG_W-1:0]   cfgVal;
  } strobes_t;
endpackage

// File: rtl/extIrqSync.sv
module extIrqSync
  import extIrqPkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] pinIn,
  output logic [NUM_EXT-1:0] syncLvl,
  output logic [NUM_EXT-1:0] rise,
  output logic [NUM_EXT-1:0] fall
);
  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    logic              prevLvl;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        chain   <= '1;
        prevLvl <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], pinIn[i]};
        prevLvl <= chain[LAST];
      end
    end

    assign syncLvl[i] = chain[LAST];
    assign rise[i]    = chain[LAST] & ~prevLvl;
    assign fall[i]    = ~chain[LAST] & prevLvl;
  end
endmodule

// File: rtl/extIrqCtrl.sv
module extIrqCtrl
  import extIrqPkg::*;
(
  input  logic [NUM_EXT-1:0] rise,
  input  logic [NUM_EXT-1:0] fall,
  input  logic [CFG_W-1:0]   cfgQ,
  input  logic [NUM_EXT-1:0] modeQ,
  input  logic [NUM_TMR-1:0] ovf,
  input  logic [NUM_EXT-1:0] ackExt,
  input  logic [NUM_TMR-1:0] ackTmr,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               bitWrEn,
  input  logic [2:0]         bitSel,
  input  logic               bitVal,
  input  logic               cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  output strobes_t           stb
);
  logic [NUM_EXT-1:0] edgeHit;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_edge
    // cfg bit 2i = falling enable, bit 2i+1 = rising enable
    assign edgeHit[i] = (fall[i] & cfgQ[2*i]) | (rise[i] & cfgQ[2*i+1]);
  end

  logic [REG_W-1:0] bitMask;
  assign bitMask = REG_W'(1) << bitSel;

  always_comb begin
    stb.extSet = edgeHit & modeQ;
    stb.extAck = ackExt & modeQ;
    stb.tmrSet = ovf;
    stb.tmrAck = ackTmr;
    stb.wrMask = regWrEn ? '1 : '0;
    stb.wrVal  = regWrData;
    if (bitWrEn) begin
      stb.wrMask = stb.wrMask | bitMask;
      stb.wrVal  = (stb.wrVal & ~bitMask) | (bitVal ? bitMask : '0);
    end
    stb.cfgWr  = cfgWrEn;
    stb.cfgVal = cfgWrData;
  end
endmodule

// File: rtl/extIrqDatapath.sv
module extIrqDatapath
  import extIrqPkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RESET = 4'b0101
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [NUM_EXT-1:0] syncLvl,
  output logic [REG_W-1:0]   regRdData,
  output logic [CFG_W-1:0]   cfgQ,
  output logic [NUM_EXT-1:0] modeQ,
  output logic [NUM_EXT-1:0] irqExt,
  output logic [NUM_TMR-1:0] irqTmr,
  output logic [NUM_TMR-1:0] runTmr
);
  logic [REG_W-1:0] regQ;

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= CFG_RESET;
    else if (stb.cfgWr) cfgQ <= stb.cfgVal;
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    localparam int MODE_BIT = BIT_EXT_MODE0 + EXT_STRIDE * i;
    localparam int FLAG_BIT = BIT_EXT_FLAG0 + EXT_STRIDE * i;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ[MODE_BIT] <= 1'b0;
        regQ[FLAG_BIT] <= 1'b0;
      end else begin
        if (stb.wrMask[MODE_BIT]) regQ[MODE_BIT] <= stb.wrVal[MODE_BIT];
        if (!regQ[MODE_BIT])             regQ[FLAG_BIT] <= 1'b0;
        else if (stb.extSet[i])          regQ[FLAG_BIT] <= 1'b1;
        else if (stb.wrMask[FLAG_BIT])   regQ[FLAG_BIT] <= stb.wrVal[FLAG_BIT];
        else if (stb.extAck[i])          regQ[FLAG_BIT] <= 1'b0;
      end
    end

    assign modeQ[i]  = regQ[MODE_BIT];
    assign irqExt[i] = regQ[MODE_BIT] ? regQ[FLAG_BIT] : ~syncLvl[i];

    // R7: edge-mode acknowledge with nothing competing clears the request
    p_ext_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
      (regQ[MODE_BIT] && stb.extAck[i] && !stb.extSet[i] &&
       !stb.wrMask[FLAG_BIT] && !stb.wrMask[MODE_BIT]) |=> !irqExt[i]);
    // R9: a set event wins over coincident clear sources
    p_ext_set_r9: assert property (@(posedge clk) disable iff (!rstN)
      (stb.extSet[i] && !stb.wrMask[MODE_BIT]) |=> irqExt[i]);
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int RUN_BIT  = BIT_TMR_RUN0 + TMR_STRIDE * i;
    localparam int FLAG_BIT = BIT_TMR_FLAG0 + TMR_STRIDE * i;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ[RUN_BIT]  <= 1'b0;
        regQ[FLAG_BIT] <= 1'b0;
      end else begin
        if (stb.wrMask[RUN_BIT]) regQ[RUN_BIT] <= stb.wrVal[RUN_BIT];
        if (stb.tmrSet[i])             regQ[FLAG_BIT] <= 1'b1;
        else if (stb.wrMask[FLAG_BIT]) regQ[FLAG_BIT] <= stb.wrVal[FLAG_BIT];
        else if (stb.tmrAck[i])        regQ[FLAG_BIT] <= 1'b0;
      end
    end

    assign irqTmr[i] = regQ[FLAG_BIT];
    assign runTmr[i] = regQ[RUN_BIT];

    // R8: overflow sets the timer request on the next cycle
    p_tmr_set_r8: assert property (@(posedge clk) disable iff (!rstN)
      stb.tmrSet[i] |=> irqTmr[i]);
    // R8: acknowledge alone clears the timer request
    p_tmr_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
      (stb.tmrAck[i] && !stb.tmrSet[i] && !stb.wrMask[FLAG_BIT]) |=> !irqTmr[i]);
    // R2: run bit only changes on a write
    p_run_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      !stb.wrMask[RUN_BIT] |=> $stable(runTmr[i]));
  end

  always_comb begin
    regRdData = regQ;
    for (int i = 0; i < NUM_EXT; i++)
      regRdData[BIT_EXT_FLAG0 + EXT_STRIDE * i] = irqExt[i];
  end
endmodule

// File: rtl/extIrqFlagUnit.sv
module extIrqFlagUnit
  import extIrqPkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  CFG_RESET   = 4'b0101
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pinIn,
  input  logic [1:0] ovf,
  input  logic [1:0] ackExt,
  input  logic [1:0] ackTmr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       bitWrEn,
  input  logic [2:0] bitSel,
  input  logic       bitVal,
  input  logic       cfgWrEn,
  input  logic [3:0] cfgWrData,
  output logic [7:0] regRdData,
  output logic [3:0] cfgRdData,
  output logic [1:0] irqExt,
  output logic [1:0] irqTmr,
  output logic [1:0] runTmr
);
  logic [1:0] syncLvl, rise, fall, modeQ;
  logic [3:0] cfgQ;
  strobes_t   stb;

  extIrqSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .syncLvl(syncLvl), .rise(rise), .fall(fall)
  );

  extIrqCtrl u_ctrl (
    .rise(rise), .fall(fall), .cfgQ(cfgQ), .modeQ(modeQ),
    .ovf(ovf), .ackExt(ackExt), .ackTmr(ackTmr),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .bitWrEn(bitWrEn), .bitSel(bitSel), .bitVal(bitVal),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .stb(stb)
  );

  extIrqDatapath #(.CFG_RESET(CFG_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .syncLvl(syncLvl),
    .regRdData(regRdData), .cfgQ(cfgQ), .modeQ(modeQ),
    .irqExt(irqExt), .irqTmr(irqTmr), .runTmr(runTmr)
  );

  assign cfgRdData = cfgQ;
endmodule

// File: tb/test_extIrqFlagUnit.sv
module test_extIrqFlagUnit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pinIn = 2'b11, ovf = '0, ackExt = '0, ackTmr = '0;
  logic       regWrEn = 1'b0, bitWrEn = 1'b0, bitVal = 1'b0, cfgWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [2:0] bitSel = '0;
  logic [3:0] cfgWrData = '0;
  logic [7:0] regRdData;
  logic [3:0] cfgRdData;
  logic [1:0] irqExt, irqTmr, runTmr;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  extIrqFlagUnit i_extIrqFlagUnit (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .ovf(ovf), .ackExt(ackExt),
    .ackTmr(ackTmr), .regWrEn(regWrEn), .regWrData(regWrData),
    .bitWrEn(bitWrEn), .bitSel(bitSel), .bitVal(bitVal),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .regRdData(regRdData),
    .cfgRdData(cfgRdData), .irqExt(irqExt), .irqTmr(irqTmr), .runTmr(runTmr)
  );

  // reference model, built from the requirements
  logic [1:0] mS1 = 2'b11, mS2 = 2'b11, mPrev = 2'b11;
  logic [7:0] mReg = '0;
  logic [3:0] mCfg = 4'b0101;

  function automatic logic [7:0] expRead();
    logic [7:0] r = mReg;
    for (int i = 0; i < 2; i++)
      if (!mReg[2*i]) r[2*i+1] = ~mS2[i];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 2'b11; mS2 = 2'b11; mPrev = 2'b11; mReg = '0; mCfg = 4'b0101;
    end else begin
      logic [7:0] msk, val, nr;
      msk = regWrEn ? 8'hFF : 8'h00;
      val = regWrData;
      if (bitWrEn) begin msk[bitSel] = 1'b1; val[bitSel] = bitVal; end
      nr = mReg;
      for (int i = 0; i < 2; i++) begin
        logic hit;
        hit = (mS2[i] & ~mPrev[i] & mCfg[2*i+1]) | (~mS2[i] & mPrev[i] & mCfg[2*i]);
        if (msk[2*i]) nr[2*i] = val[2*i];
        if (!mReg[2*i])         nr[2*i+1] = 1'b0;
        else if (hit)           nr[2*i+1] = 1'b1;
        else if (msk[2*i+1])    nr[2*i+1] = val[2*i+1];
        else if (ackExt[i])     nr[2*i+1] = 1'b0;
        if (msk[4+2*i]) nr[4+2*i] = val[4+2*i];
        if (ovf[i])             nr[5+2*i] = 1'b1;
        else if (msk[5+2*i])    nr[5+2*i] = val[5+2*i];
        else if (ackTmr[i])     nr[5+2*i] = 1'b0;
      end
      mReg = nr;
      if (cfgWrEn) mCfg = cfgWrData;
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [7:0] e = expRead();
    check(e[0] ? "R5 ext0 flag" : "R4 ext0 level", 32'(regRdData[1]), 32'(e[1]));
    check(e[2] ? "R5 ext1 flag" : "R4 ext1 level", 32'(regRdData[3]), 32'(e[3]));
    check("R8 timer flags", 32'({regRdData[7], regRdData[5]}), 32'({e[7], e[5]}));
    check("R2 mode/run bits", 32'(regRdData & 8'h55), 32'(e & 8'h55));
    check("R5 edge select", 32'(cfgRdData), 32'(mCfg));
    check("R11 request lines", 32'({irqTmr, irqExt}), 32'({e[7], e[5], e[3], e[1]}));
    check("R2 run outputs", 32'(runTmr), 32'({e[6], e[4]}));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    regWrEn = 1'b0; bitWrEn = 1'b0; cfgWrEn = 1'b0;
    ovf = '0; ackExt = '0; ackTmr = '0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset byte", 32'(regRdData), 32'h00);
    check("R1 reset edge select", 32'(cfgRdData), 32'h5);
    check("R1 reset requests", 32'({irqTmr, irqExt}), 32'h0);

    bitWrEn = 1'b1; bitSel = 3'd6; bitVal = 1'b1; tick();
    check("R3 single bit write", 32'(regRdData), 32'h40);
    check("R3 run output", 32'(runTmr), 32'h2);

    regWrEn = 1'b1; regWrData = 8'h11; tick();   // run0 + edge mode on pin 0
    check("R2 byte write", 32'(regRdData), 32'h11);
    pinIn[0] = 1'b0; ticks(2);
    check("R5 not yet set", 32'(irqExt[0]), 32'h0);
    tick();
    check("R5 falling edge sets", 32'(irqExt[0]), 32'h1);
    ackExt[0] = 1'b1; tick();
    check("R7 ack clears edge flag", 32'(irqExt[0]), 32'h0);

    cfgWrEn = 1'b1; cfgWrData = 4'b0111; tick();
    pinIn[0] = 1'b1; ticks(3);
    check("R6 rising with both set", 32'(irqExt[0]), 32'h1);
    ackExt[0] = 1'b1; tick();
    pinIn[0] = 1'b0; ticks(3);
    check("R6 falling with both set", 32'(irqExt[0]), 32'h1);
    ackExt[0] = 1'b1; cfgWrEn = 1'b1; cfgWrData = 4'b0100; tick();
    pinIn[0] = 1'b1; ticks(3); pinIn[0] = 1'b0; ticks(3);
    check("R6 no enables no flag", 32'(irqExt[0]), 32'h0);

    ovf[0] = 1'b1; ackTmr[0] = 1'b1; tick();
    check("R9 overflow beats ack", 32'(irqTmr[0]), 32'h1);
    ackTmr[0] = 1'b1; tick();
    check("R8 timer ack clears", 32'(irqTmr[0]), 32'h0);
    regWrEn = 1'b1; regWrData = 8'h91; tick();
    check("R10 software forces timer flag", 32'(irqTmr[1]), 32'h1);
    bitWrEn = 1'b1; bitSel = 3'd1; bitVal = 1'b1; tick();
    check("R10 software forces ext flag", 32'(irqExt[0]), 32'h1);

    pinIn[1] = 1'b0; ticks(2);                   // pin 1 in level mode
    check("R4 level low requests", 32'(regRdData[3]), 32'h1);
    ackExt[1] = 1'b1; tick();
    check("R4 ack ignored in level", 32'(irqExt[1]), 32'h1);
    bitWrEn = 1'b1; bitSel = 3'd3; bitVal = 1'b0; tick();
    check("R4 write ignored in level", 32'(irqExt[1]), 32'h1);
    pinIn[1] = 1'b1; ticks(2);
    check("R4 level high releases", 32'(irqExt[1]), 32'h0);

    void'($urandom(32'd20240611));
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(7) == 0) pinIn[0] = ~pinIn[0];
      if ($urandom_range(7) == 0) pinIn[1] = ~pinIn[1];
      ovf    = 2'($urandom_range(15) == 0 ? $urandom_range(3) : 0);
      ackExt = 2'($urandom_range(5) == 0 ? $urandom_range(3) : 0);
      ackTmr = 2'($urandom_range(5) == 0 ? $urandom_range(3) : 0);
      if ($urandom_range(39) == 0) begin regWrEn = 1'b1; regWrData = 8'($urandom); end
      if ($urandom_range(29) == 0) begin
        bitWrEn = 1'b1; bitSel = 3'($urandom); bitVal = 1'($urandom);
      end
      if ($urandom_range(59) == 0) begin cfgWrEn = 1'b1; cfgWrData = 4'($urandom); end
      tick();   // R9 R10 R11 exercised by model comparison
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule